// File: doc/BRIEF.md
# Dual External Interrupt Sense Unit

This block watches two external interrupt request pins and turns each into one interrupt request line for a CPU interrupt controller. Each raw pin first passes through a two-flop synchroniser and then into a sampling register that takes one sample per clock. A per-pin mode bit chooses how the request is formed. In low-level mode the request is simply the inverse of the latest sample. In falling-edge mode a sticky flag is set when one sample reads high and the following sample reads low.

In falling-edge mode the flag stays set until the controller pulses that pin's acknowledge strobe on entry to the service routine. In low-level mode nothing is latched: the request is asserted for as long as the pin stays low, so it asserts again if the pin is still low when service ends. A flag read port exposes the latched edge flags to the CPU. Priority, vectoring and the choice of pins are left to the surrounding logic.

Top module: `ext_irq_sense`

## Requirements
- R1: During and after a synchronous active-low reset, and before any pin has been low, both `irq_req` bits and both `flag_rd` bits read 0. All synchroniser and sampling stages reset to high, which is the inactive level.
- R2: With `mode_edge[i]` = 0 (low-level mode), `irq_req[i]` goes to 1 on the third rising clock edge after `pin_raw[i]` goes low. It returns to 0 on the third rising edge after the pin goes high. There is one synchroniser edge, a second synchroniser edge, then the sampling edge.
- R3: With `mode_edge[i]` = 1 (falling-edge mode), a high sample followed by a low sample sets the edge flag. `irq_req[i]` rises on the fourth rising edge after `pin_raw[i]` falls.
- R4: In falling-edge mode the flag, and so `irq_req[i]`, stays at 1 after the pin returns high and until it is acknowledged.
- R5: A one-cycle pulse on `ack[i]`, with no new falling sample pair in that cycle, clears the edge flag of pin i on that clock edge.
- R6: If `ack[i]` arrives in the same cycle as a new high-then-low sample pair, the flag of pin i stays at 1.
- R7: Any change of `mode_edge[i]` clears the latched flag of pin i on the next clock edge, and no flag is set in that cycle.
- R8: In low-level mode `ack[i]` has no effect. `irq_req[i]` keeps following the sampled pin.
- R9: `flag_rd[i]` always reads the latched edge flag. In falling-edge mode it equals `irq_req[i]`. In low-level mode it reads 0 once the mode has been low-level for one cycle.
- R10: In falling-edge mode a rising transition on the pin never sets the flag.
- R11: The two pins are independent. Inputs for one pin never change the request or flag of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_raw | input | 2 | Asynchronous interrupt pins, active low |
| mode_edge | input | 2 | Per-pin mode: 0 = low level, 1 = falling edge |
| ack | input | 2 | Per-pin acknowledge strobe from the interrupt controller |
| flag_rd | output | 2 | Latched edge flags, for the CPU to read |
| irq_req | output | 2 | Per-pin interrupt request |

## Verification
The bench counts the exact latency of the three-register path in level mode and of the four-register path in edge mode. A design with one stage too few or too many would show the request one cycle early or late. It targets an acknowledge that lands in the same cycle as a fresh falling pair: a design that gave acknowledge priority would drop that second interrupt. It also targets a mode switch while a flag is pending, where a stale flag would fire after switching back, and an acknowledge in level mode, which must not mask a pin that is still low. A long pseudo-random sweep then compares both pins every cycle against an arithmetic model to catch any coupling between the pins, and any detection of rising edges.

// File: rtl/ext_irq_pkg.sv
// Package: shared types and defaults for the external interrupt sense unit.
// Assumes: nothing beyond the standard language.
package ext_irq_pkg;
    // Per-pin detection mode; the encoding matches the mode input bit.
    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    localparam int unsigned DEF_PINS        = 2;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Purpose: brings one asynchronous pin into the clock domain through a
// chain of flops. Assumes STAGES >= 2. Every stage resets to 1, the
// inactive level of an active-low request.
module irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o
);
    localparam int unsigned TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[TOP-1:0], raw_i};
        end
    end

    assign sync_o = chain_q[TOP];
endmodule

// File: rtl/irq_sample.sv
// Module: irq_sample
// Purpose: takes one sample of the synchronised pin per clock, keeps the
// sample before it, and flags a high-then-low pair. Assumes sync_i is
// already in the clock domain. Both registers reset to 1.
module irq_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic cur_o,
    output logic fall_o
);
    logic cur_q;
    logic prev_q;

    // Record the current sample and the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            cur_q  <= sync_i;
            prev_q <= cur_q;
        end
    end

    // A falling pair is an earlier high followed by a current low.
    always_comb begin
        fall_o = prev_q & ~cur_q;
    end

    assign cur_o = cur_q;

    // R10
    rise_not_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_q && cur_q) |-> !fall_o);
endmodule

// File: rtl/irq_flag.sv
// Module: irq_flag
// Purpose: forms the request of one pin from its samples and its mode.
// Edge mode keeps a sticky flag that is cleared by acknowledge. Level
// mode passes the inverted sample straight through. Assumes the mode
// input is synchronous. A mode change clears the flag, and a new falling
// pair outranks an acknowledge in the same cycle.
module irq_flag
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode_i,
    input  logic   cur_i,
    input  logic   fall_i,
    input  logic   ack_i,
    output logic   flag_o,
    output logic   req_o
);
    sense_e mode_q;
    logic   flag_q;
    logic   mode_chg;
    logic   set_flag;
    logic   flag_d;

    // Remember last cycle's mode so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SENSE_LEVEL;
        end else begin
            mode_q <= mode_i;
        end
    end

    // Decide the next flag: mode change clears, then set, then ack.
    always_comb begin
        mode_chg = (mode_i != mode_q);
        set_flag = (mode_i == SENSE_EDGE) && fall_i;
        flag_d   = flag_q;
        if (mode_chg) begin
            flag_d = 1'b0;
        end else if (set_flag) begin
            flag_d = 1'b1;
        end else if (ack_i) begin
            flag_d = 1'b0;
        end
    end

    // Hold the sticky edge flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    // Pick the request source for the current mode.
    always_comb begin
        req_o = (mode_i == SENSE_EDGE) ? flag_q : ~cur_i;
    end

    assign flag_o = flag_q;

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !fall_i) |=> !flag_o);
    // R6
    ack_edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_EDGE && mode_q == SENSE_EDGE && fall_i) |=> flag_o);
    // R7
    mode_change_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> !flag_o);
    // R9
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LEVEL && mode_q == SENSE_LEVEL) |-> !flag_o);
endmodule

// File: rtl/ext_irq_sense.sv
// Module: ext_irq_sense (top)
// Purpose: per-pin synchroniser, sampler and request former for the
// external interrupt pins. Assumes mode_edge and ack are synchronous to
// clk and that pin_raw is asynchronous and active low.
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = DEF_PINS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] mode_edge,
    input  logic [NUM_PINS-1:0] ack,
    output logic [NUM_PINS-1:0] flag_rd,
    output logic [NUM_PINS-1:0] irq_req
);
    logic [NUM_PINS-1:0] sync_w;
    logic [NUM_PINS-1:0] cur_w;
    logic [NUM_PINS-1:0] fall_w;

    // One independent sense channel per pin.
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
        irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (pin_raw[gi]),
            .sync_o (sync_w[gi])
        );

        irq_sample u_sample (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (sync_w[gi]),
            .cur_o  (cur_w[gi]),
            .fall_o (fall_w[gi])
        );

        irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (sense_e'(mode_edge[gi])),
            .cur_i  (cur_w[gi]),
            .fall_i (fall_w[gi]),
            .ack_i  (ack[gi]),
            .flag_o (flag_rd[gi]),
            .req_o  (irq_req[gi])
        );

        // R2
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_edge[gi] |-> (irq_req[gi] == !$past(sync_w[gi])));
        // R9
        edge_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode_edge[gi] |-> (irq_req[gi] == flag_rd[gi]));
    end
endmodule

// File: tb/ext_irq_sense_bench.sv
// Bench: directed latency and corner scenarios, then a long pseudo-random
// sweep compared each cycle against an arithmetic model of both pins.
module ext_irq_sense_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 2;
    localparam int SWEEP      = 6000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin_raw;
    logic [NP-1:0] mode_edge;
    logic [NP-1:0] ack;
    logic [NP-1:0] flag_rd;
    logic [NP-1:0] irq_req;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state: the pin seen through 2 sync stages, sample, previous.
    logic [NP-1:0] m_s1, m_s2, m_cur, m_prev, m_flag, m_mq;

    ext_irq_sense u_ext_irq_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw   (pin_raw),
        .mode_edge (mode_edge),
        .ack       (ack),
        .flag_rd   (flag_rd),
        .irq_req   (irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s t=%0t got=%b exp=%b", req, $time, got, exp);
        end
    endtask

    // Advance one edge, update the model from the inputs that were applied,
    // then compare both pins against it.
    task automatic tick();
        logic [NP-1:0] nf;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_cur = '1; m_prev = '1;
            m_flag = '0; m_mq = '0;
        end else begin
            nf = m_flag;
            for (int i = 0; i < NP; i++) begin
                if (mode_edge[i] != m_mq[i]) nf[i] = 1'b0;
                else if (mode_edge[i] && m_prev[i] && !m_cur[i]) nf[i] = 1'b1;
                else if (ack[i]) nf[i] = 1'b0;
            end
            m_flag = nf;
            m_prev = m_cur; m_cur = m_s2; m_s2 = m_s1; m_s1 = pin_raw;
            m_mq   = mode_edge;
        end
        for (int i = 0; i < NP; i++) begin
            check(mode_edge[i] ? "R3 model irq" : "R2 model irq", irq_req[i],
                  mode_edge[i] ? m_flag[i] : ~m_cur[i]);
            check("R9 model flag", flag_rd[i], m_flag[i]);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_raw = '1; mode_edge = '0; ack = '0;
        ticks(3);
        check("R1 irq in reset", irq_req[0] | irq_req[1], 1'b0);
        rst_n = 1'b1;
        ticks(2);
        check("R1 irq after reset", irq_req[0] | irq_req[1], 1'b0);
        check("R1 flags after reset", flag_rd[0] | flag_rd[1], 1'b0);

        // R2 level latency: three edges.
        pin_raw[0] = 1'b0;
        ticks(2); check("R2 not yet", irq_req[0], 1'b0);
        tick();   check("R2 asserted", irq_req[0], 1'b1);
        check("R9 level flag", flag_rd[0], 1'b0);
        // R8 ack ignored in level mode.
        ack[0] = 1'b1; tick(); ack[0] = 1'b0;
        tick(); check("R8 ack ignored", irq_req[0], 1'b1);
        pin_raw[0] = 1'b1;
        ticks(2); check("R2 still low", irq_req[0], 1'b1);
        tick();   check("R2 released", irq_req[0], 1'b0);

        // R3 edge latency: four edges.
        mode_edge[0] = 1'b1; ticks(2);
        pin_raw[0] = 1'b0;
        ticks(3); check("R3 not yet", irq_req[0], 1'b0);
        tick();   check("R3 flag set", irq_req[0], 1'b1);
        check("R9 edge flag", flag_rd[0], 1'b1);
        check("R11 other pin", irq_req[1], 1'b0);
        // R4 sticky after pin high.
        pin_raw[0] = 1'b1; ticks(6);
        check("R4 sticky", irq_req[0], 1'b1);
        // R5 ack clears.
        ack[0] = 1'b1; tick(); ack[0] = 1'b0;
        check("R5 ack clears", flag_rd[0], 1'b0);
        // R10 rising never sets.
        pin_raw[0] = 1'b0; ticks(5);
        ack[0] = 1'b1; tick(); ack[0] = 1'b0;
        pin_raw[0] = 1'b1; ticks(6);
        check("R10 rise ignored", irq_req[0], 1'b0);

        // R6 ack coincides with fresh falling pair.
        pin_raw[0] = 1'b0; ticks(4);
        check("R6 first flag", flag_rd[0], 1'b1);
        pin_raw[0] = 1'b1; ticks(4);
        pin_raw[0] = 1'b0; ticks(3);
        ack[0] = 1'b1; tick(); ack[0] = 1'b0;
        check("R6 flag kept", flag_rd[0], 1'b1);
        ack[0] = 1'b1; tick(); ack[0] = 1'b0;
        check("R6 later ack", flag_rd[0], 1'b0);

        // R7 mode change clears a pending flag.
        pin_raw[0] = 1'b1; ticks(4);
        pin_raw[0] = 1'b0; ticks(4);
        check("R7 pending", flag_rd[0], 1'b1);
        mode_edge[0] = 1'b0; tick();
        check("R7 cleared", flag_rd[0], 1'b0);
        mode_edge[0] = 1'b1; tick();
        check("R7 no stale", irq_req[0], 1'b0);
        check("R11 pin1 quiet", irq_req[1] | flag_rd[1], 1'b0);

        // Sweep: random holds, rare mode changes, random acks.
        for (int c = 0; c < SWEEP; c++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(0, 2) == 0) pin_raw[i] = ~pin_raw[i];
                if ($urandom_range(0, 40) == 0) mode_edge[i] = ~mode_edge[i];
                ack[i] = ($urandom_range(0, 5) == 0);
            end
            tick();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule